// File: doc/BRIEF.md
# Serial Debug Port Frame Decoder

This block is the target end of a synchronous serial debug link. An external tool clocks 35-bit frames into it: a start bit, a mode bit, a control bit and a 32-bit payload, most significant bit first. Each finished frame is classified. It can be an instruction word or a data word for the CPU, a write to the trap-enable register, a port command, a no-operation, or a reserved encoding. While the frame shifts in, the block shifts a 35-bit response out on the same serial clock. The response starts with a low ready bit, then two status bits and a 32-bit field.

Instruction and data words go to the CPU on a valid/ready stream. Once a word is offered, `cpu_valid` stays high and `cpu_word` stays constant until `cpu_ready` is seen. Until the CPU takes the word, the port is busy: the serial output idles high and start bits are ignored. Words the CPU sends back come in on a second valid/ready stream. `rsp_ready` is high only while the one-word return buffer is empty, and a buffered word goes out in the next response frame. The CPU states whether it expects an instruction or data. A frame tagged the other way is not delivered and is reported as a sequence error.

The system clock oversamples the serial clock. Input bits are captured on serial-clock rising edges, and output bits change on serial-clock falling edges.

Top module: `dbg_serial_port`

## Requirements
- R1: A frame is a 1 start bit followed by mode, control and a 32-bit payload, most significant bit first, each sampled on a rising edge of `ser_clk`. The frame is acted on at the rising edge that captures the last payload bit.
- R2: While the port is waiting for a frame, a low `ser_in` is ignored. A start bit is also ignored while the port is busy (an undelivered CPU word is pending). Stray bits do not disturb the alignment of the next accepted frame.
- R3: mode=0 with control=0 offers the payload on the CPU stream with `cpu_is_data`=0. mode=0 with control=1 offers it with `cpu_is_data`=1. Either is offered only when the tag matches `cpu_want_data`.
- R4: A mode=0 frame whose control bit differs from `cpu_want_data` is not offered to the CPU. The next response carries status 01 with a zero data field.
- R5: mode=1 with control=0 loads the 32-bit payload into `trap_en`.
- R6: mode=1 with control=1 is a port command when payload[31:25]=0011111. The value of payload[24:0] selects the command. A value of 1 pulses `brk_negate` for one cycle. A value of 2 pulses `core_reset` for one cycle. A value of 3 sets `fdl_active`, and 4 clears it.
- R7: Any other mode=1, control=1 payload that is not zero is reserved. It changes no output, and the next response reports null status 11 unless something else is pending.
- R8: mode=1, control=1 with an all-zero payload is a NOP. It has no effect beyond clocking out the pending response.
- R9: Each response is a 0 ready bit, two status bits and a 32-bit field, most significant bit first, with each bit changing on a falling edge of `ser_clk`. The response is fixed when the start bit is captured. Its status is chosen by this priority: 01 sequence error, then 00 returned CPU word, then 10 when `cpu_irq` is high, otherwise 11 null. Every status except 00 has a zero field.
- R10: Between frames, `ser_out` is 0 when the port can take a frame and 1 while a CPU word awaits acceptance.
- R11: `cpu_valid` and `cpu_word` hold until `cpu_ready`. `rsp_ready` is high exactly when the return buffer is empty. A word accepted there is returned in the next response and then frees the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples `ser_clk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the tool |
| ser_in | input | 1 | Serial frame input |
| ser_out | output | 1 | Serial response output and ready line |
| cpu_want_data | input | 1 | 1 when the CPU expects data, 0 when it expects an instruction |
| cpu_irq | input | 1 | CPU interrupt indication for the response status |
| cpu_valid | output | 1 | Word offered to the CPU |
| cpu_ready | input | 1 | CPU takes the offered word |
| cpu_word | output | 32 | Instruction or data word |
| cpu_is_data | output | 1 | 1 for data, 0 for instruction |
| rsp_valid | input | 1 | CPU offers a word to return |
| rsp_ready | output | 1 | Return buffer is empty |
| rsp_data | input | 32 | Word to return |
| trap_en | output | 32 | Trap-enable register |
| brk_negate | output | 1 | One-cycle breakpoint-negate pulse |
| core_reset | output | 1 | One-cycle processor-reset pulse |
| fdl_active | output | 1 | Fast-download mode flag |

## Verification
The assertions check these properties on every cycle:
- the CPU stream and the return buffer hold their words stable under back-pressure;
- the line idles high while a word is pending;
- the frame counter is at rest between frames;
- the command pulses are mutually exclusive and the fast-download flag moves only when a frame completes;
- a mismatched frame never raises `cpu_valid`.

Other behaviour can only be shown by the bench scenarios, which compare against a frame-level reference model on every clock:
- the status priority and data content of the serial response;
- the decode of every frame type, including reserved commands and stray start bits sent while busy;
- the one-frame delay before a returned word or a sequence error appears.

// File: rtl/sdbg_pkg.sv
package sdbg_pkg;
  typedef enum logic [2:0] {
    FK_INSTR, FK_DATA, FK_TRAP, FK_CMD, FK_NOP, FK_RSVD
  } frame_kind_e;

  typedef enum logic [1:0] {
    RS_DATA   = 2'b00,
    RS_SEQERR = 2'b01,
    RS_IRQ    = 2'b10,
    RS_NULL   = 2'b11
  } rsp_stat_e;

  localparam logic [6:0] CMD_PREFIX = 7'b0011111;
  localparam int CMD_COUNT = 4;
endpackage

// File: rtl/sdbg_shifter.sv
module sdbg_shifter #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_in,
  input  logic          port_rdy,
  input  logic [PW+1:0] out_word,
  output logic          ser_out,
  output logic          start_o,
  output logic          done_o,
  output logic [PW+1:0] frame_o
);
  localparam int FL = PW + 3;
  localparam int CW = $clog2(FL);
  localparam logic [CW-1:0] LAST = CW'(FL - 1);

  logic          sclk_q;
  logic          active;
  logic [CW-1:0] cnt;
  logic [PW:0]   in_sr;
  logic [PW+1:0] out_sr;
  logic          rise, fall;

  assign rise    = ser_clk & ~sclk_q;
  assign fall    = ~ser_clk & sclk_q;
  assign start_o = !active && rise && ser_in && port_rdy;
  assign done_o  = active && rise && (cnt == LAST);
  assign frame_o = {in_sr, ser_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      in_sr   <= '0;
      out_sr  <= '0;
      ser_out <= 1'b0;
    end else begin
      sclk_q <= ser_clk;
      if (!active) begin
        ser_out <= ~port_rdy;
        if (start_o) begin
          active <= 1'b1;
          cnt    <= CW'(1);
          out_sr <= out_word;
        end
      end else begin
        if (fall) begin
          ser_out <= out_sr[PW+1];
          out_sr  <= {out_sr[PW:0], 1'b0};
        end
        if (rise) begin
          in_sr <= {in_sr[PW-1:0], ser_in};
          if (cnt == LAST) begin
            active <= 1'b0;
            cnt    <= '0;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cnt == '0); // R2
  AST_START_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !port_rdy) |=> !active); // R2
endmodule

// File: rtl/sdbg_decode.sv
module sdbg_decode
  import sdbg_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic [PW+1:0] frame,
  output frame_kind_e   kind,
  output logic [1:0]    cmd_id,
  output logic [PW-1:0] payload
);
  localparam int LOW_W = PW - 7;

  logic          mode, ctrl;
  logic [LOW_W-1:0] low;
  logic [LOW_W-1:0] low_m1;

  assign mode    = frame[PW+1];
  assign ctrl    = frame[PW];
  assign payload = frame[PW-1:0];
  assign low     = payload[LOW_W-1:0];
  assign low_m1  = low - LOW_W'(1);

  always_comb begin
    kind   = FK_NOP;
    cmd_id = 2'd0;
    if (!mode) begin
      kind = ctrl ? FK_DATA : FK_INSTR;
    end else if (!ctrl) begin
      kind = FK_TRAP;
    end else if (payload == '0) begin
      kind = FK_NOP;
    end else if (payload[PW-1:PW-7] == CMD_PREFIX && low != '0 &&
                 low <= LOW_W'(CMD_COUNT)) begin
      kind   = FK_CMD;
      cmd_id = low_m1[1:0];
    end else begin
      kind = FK_RSVD;
    end
  end
endmodule

// File: rtl/sdbg_resp.sv
module sdbg_resp
  import sdbg_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          seq_set,
  input  logic          irq,
  input  logic          rsp_valid,
  input  logic [PW-1:0] rsp_data,
  output logic          rsp_ready,
  output logic [PW+1:0] out_word
);
  logic          seq_pend;
  logic          held;
  logic [PW-1:0] word;

  assign rsp_ready = ~held;

  always_comb begin
    if (seq_pend)  out_word = {RS_SEQERR, {PW{1'b0}}};
    else if (held) out_word = {RS_DATA, word};
    else if (irq)  out_word = {RS_IRQ, {PW{1'b0}}};
    else           out_word = {RS_NULL, {PW{1'b0}}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_pend <= 1'b0;
      held     <= 1'b0;
      word     <= '0;
    end else begin
      if (seq_set)               seq_pend <= 1'b1;
      else if (load && seq_pend) seq_pend <= 1'b0;
      if (load && !seq_pend && held) begin
        held <= 1'b0;
      end else if (rsp_valid && !held) begin
        held <= 1'b1;
        word <= rsp_data;
      end
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !load) |=> (held && $stable(word))); // R11
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port
  import sdbg_pkg::*;
#(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_clk,
  input  logic          ser_in,
  output logic          ser_out,
  input  logic          cpu_want_data,
  input  logic          cpu_irq,
  output logic          cpu_valid,
  input  logic          cpu_ready,
  output logic [PW-1:0] cpu_word,
  output logic          cpu_is_data,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [PW-1:0] rsp_data,
  output logic [PW-1:0] trap_en,
  output logic          brk_negate,
  output logic          core_reset,
  output logic          fdl_active
);
  logic          start, done;
  logic [PW+1:0] frame, out_word;
  frame_kind_e   kind;
  logic [1:0]    cmd_id;
  logic [PW-1:0] payload;
  logic          is_cpu, tag_data, seq_set;

  sdbg_shifter #(.PW(PW)) u_shift (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in),
    .port_rdy(~cpu_valid), .out_word(out_word), .ser_out(ser_out),
    .start_o(start), .done_o(done), .frame_o(frame)
  );

  sdbg_decode #(.PW(PW)) u_dec (
    .frame(frame), .kind(kind), .cmd_id(cmd_id), .payload(payload)
  );

  assign is_cpu   = (kind == FK_INSTR) || (kind == FK_DATA);
  assign tag_data = (kind == FK_DATA);
  assign seq_set  = done && is_cpu && (tag_data != cpu_want_data);

  sdbg_resp #(.PW(PW)) u_resp (
    .clk(clk), .rst_n(rst_n), .load(start), .seq_set(seq_set),
    .irq(cpu_irq), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_ready(rsp_ready), .out_word(out_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_valid   <= 1'b0;
      cpu_word    <= '0;
      cpu_is_data <= 1'b0;
      trap_en     <= '0;
      brk_negate  <= 1'b0;
      core_reset  <= 1'b0;
      fdl_active  <= 1'b0;
    end else begin
      brk_negate <= 1'b0;
      core_reset <= 1'b0;
      if (cpu_valid && cpu_ready) cpu_valid <= 1'b0;
      if (done) begin
        unique case (kind)
          FK_INSTR, FK_DATA: begin
            if (!seq_set) begin
              cpu_valid   <= 1'b1;
              cpu_word    <= payload;
              cpu_is_data <= tag_data;
            end
          end
          FK_TRAP: trap_en <= payload;
          FK_CMD: begin
            unique case (cmd_id)
              2'd0: brk_negate <= 1'b1;
              2'd1: core_reset <= 1'b1;
              2'd2: fdl_active <= 1'b1;
              2'd3: fdl_active <= 1'b0;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  AST_CPU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_ready) |=> (cpu_valid && $stable(cpu_word) && $stable(cpu_is_data))); // R11
  AST_BUSY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> ser_out); // R10
  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({brk_negate, core_reset})); // R6
  AST_FDL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(fdl_active)); // R6
  AST_SEQ_NO_DELIVER: assert property (@(posedge clk) disable iff (!rst_n)
    seq_set |=> !cpu_valid); // R4
  AST_TRAP_ONLY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(trap_en)); // R5
endmodule

// File: tb/dbg_serial_port_tb.sv
module dbg_serial_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_in = 1'b0;
  logic ser_out;
  logic cpu_want_data = 1'b0, cpu_irq = 1'b0;
  logic cpu_valid, cpu_ready = 1'b0;
  logic [31:0] cpu_word;
  logic cpu_is_data;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic [31:0] trap_en;
  logic brk_negate, core_reset, fdl_active;

  always #10 clk = ~clk;

  dbg_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_in(ser_in), .ser_out(ser_out),
    .cpu_want_data(cpu_want_data), .cpu_irq(cpu_irq), .cpu_valid(cpu_valid),
    .cpu_ready(cpu_ready), .cpu_word(cpu_word), .cpu_is_data(cpu_is_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .trap_en(trap_en), .brk_negate(brk_negate), .core_reset(core_reset),
    .fdl_active(fdl_active)
  );

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  // reference model state
  logic [31:0] m_trap = '0, m_cw = '0, m_held_w = '0;
  bit m_fdl = 0, m_cv = 0, m_cd = 0, m_brk = 0, m_rst = 0, m_seq = 0, m_held = 0;
  logic [33:0] exp_resp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // per-clock comparison with the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(trap_en == m_trap, "R5 trap_en", trap_en, m_trap);
      chk(fdl_active == m_fdl, "R6 fdl_active", fdl_active, m_fdl);
      chk(brk_negate == m_brk, "R6 brk_negate", brk_negate, m_brk);
      chk(core_reset == m_rst, "R6 core_reset", core_reset, m_rst);
      chk(cpu_valid == m_cv, "R3 cpu_valid", cpu_valid, m_cv);
      chk(rsp_ready == !m_held, "R11 rsp_ready", rsp_ready, !m_held);
    end
  end

  task automatic model_start();
    if (m_seq) begin exp_resp = {2'b01, 32'h0}; m_seq = 0; end
    else if (m_held) begin exp_resp = {2'b00, m_held_w}; m_held = 0; end
    else if (cpu_irq) exp_resp = {2'b10, 32'h0};
    else exp_resp = {2'b11, 32'h0};
  endtask

  task automatic model_decode(input bit m, input bit c, input logic [31:0] pl);
    if (!m) begin
      if (c != cpu_want_data) m_seq = 1;
      else begin m_cv = 1; m_cw = pl; m_cd = c; end
    end else if (!c) begin
      m_trap = pl;
    end else if (pl[31:25] == 7'b0011111) begin
      case (pl[24:0])
        25'd1: m_brk = 1;
        25'd2: m_rst = 1;
        25'd3: m_fdl = 1;
        25'd4: m_fdl = 0;
        default: ;
      endcase
    end
  endtask

  task automatic send_frame(input bit m, input bit c, input logic [31:0] pl, input string req);
    logic [34:0] bits;
    logic [34:0] got;
    bits = {1'b1, m, c, pl};
    for (int i = 34; i >= 0; i--) begin
      @(negedge clk); ser_clk = 1'b0; ser_in = bits[i];
      repeat (3) @(negedge clk);
      got[i] = ser_out;
      ser_clk = 1'b1;
      @(posedge clk);
      if (i == 34) model_start();
      if (i == 0) begin
        model_decode(m, c, pl);
        @(posedge clk);
        m_brk = 0; m_rst = 0;
      end
      repeat (2) @(negedge clk);
    end
    @(negedge clk); ser_clk = 1'b0; ser_in = 1'b0;
    chk(got[34] == 1'b0, "R9 ready bit", got[34], 0);
    chk(got[33:0] == exp_resp, req, got[33:0], exp_resp);
  endtask

  task automatic idle_clocks(input int n, input bit v);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ser_clk = 1'b0; ser_in = v;
      repeat (3) @(negedge clk); ser_clk = 1'b1;
      repeat (4) @(negedge clk);
    end
    @(negedge clk); ser_clk = 1'b0; ser_in = 1'b0;
  endtask

  task automatic cpu_take(input logic [31:0] w, input bit d, input string req);
    @(negedge clk);
    chk(cpu_valid && cpu_word == w, req, cpu_word, w);
    chk(cpu_is_data == d, req, cpu_is_data, d);
    cpu_ready = 1'b1;
    @(posedge clk); m_cv = 0;
    @(negedge clk); cpu_ready = 1'b0;
  endtask

  task automatic push_rsp(input logic [31:0] w);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_data = w;
    @(posedge clk); m_held = 1; m_held_w = w;
    @(negedge clk); rsp_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ser_out == 1'b0 && !cpu_valid && trap_en == 0 && !fdl_active,
        "R10 reset state", {ser_out, cpu_valid, fdl_active}, 0);

    // R2: idle low line is ignored
    idle_clocks(12, 1'b0);
    chk(ser_out == 1'b0, "R2 idle low ignored", ser_out, 0);
    // R8 / R9: NOP with nothing pending answers null
    send_frame(1, 1, 32'h0, "R8 NOP null response");
    // R5 / R1
    send_frame(1, 0, 32'hA5A5_0F0F, "R5 trap write resp");
    send_frame(1, 0, 32'h8000_0001, "R1 trap second write");
    // R3 instruction
    cpu_want_data = 1'b0;
    send_frame(0, 0, 32'h1234_5678, "R3 instr resp");
    @(negedge clk);
    chk(ser_out == 1'b1, "R10 busy line high", ser_out, 1);
    // R2: stray start bit while busy is ignored
    idle_clocks(1, 1'b1);
    idle_clocks(3, 1'b0);
    cpu_take(32'h1234_5678, 1'b0, "R3 instr word");
    @(negedge clk);
    chk(ser_out == 1'b0, "R10 ready again", ser_out, 0);
    send_frame(1, 0, 32'h0000_FFFF, "R2 alignment after stray");
    // R3 data
    cpu_want_data = 1'b1;
    send_frame(0, 1, 32'hCAFE_0001, "R3 data resp");
    cpu_take(32'hCAFE_0001, 1'b1, "R3 data word");
    // R4 sequence error
    send_frame(0, 0, 32'h0BAD_0BAD, "R4 mismatch frame");
    cpu_irq = 1'b1;
    send_frame(1, 1, 32'h0, "R4 seq error reported over irq");
    send_frame(1, 1, 32'h0, "R9 irq status");
    cpu_irq = 1'b0;
    cpu_want_data = 1'b0;
    send_frame(0, 1, 32'h0000_0077, "R4 data while instr expected");
    send_frame(1, 1, 32'h0, "R4 seq error again");
    // R11 return word
    push_rsp(32'hDEAD_BEEF);
    cpu_irq = 1'b1;
    send_frame(1, 1, 32'h0, "R11 returned word in response");
    cpu_irq = 1'b0;
    send_frame(1, 1, 32'h0, "R9 null after word");
    // R6 commands
    send_frame(1, 1, 32'h3E00_0001, "R6 negate brk");
    send_frame(1, 1, 32'h3E00_0002, "R6 reset pulse");
    send_frame(1, 1, 32'h3E00_0003, "R6 fdl on");
    // R7 reserved
    send_frame(1, 1, 32'h3E00_0009, "R7 reserved low field");
    send_frame(1, 1, 32'h1234_5678, "R7 reserved prefix");
    chk(fdl_active == 1'b1, "R7 fdl unchanged", fdl_active, 1);
    send_frame(1, 1, 32'h3E00_0004, "R7 null after reserved");
    send_frame(1, 1, 32'h0, "R6 after fdl off");
    chk(fdl_active == 1'b0, "R6 fdl off", fdl_active, 0);

    repeat (10) @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule